// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns a serial line into characters for a receive queue. It is driven by a sample-tick enable. In oversampled mode there are sixteen ticks per bit. In single-tick mode each tick is one bit period and samples the line directly. A character holds 5 to 8 data bits, least significant bit first. An optional parity bit may follow: even, odd, or a fixed level. One stop bit ends the character.

Each finished character is offered to the downstream queue as a one-cycle write. The write carries the character, a parity-error flag, a framing-error flag and a compare-match flag. The compare flag marks a character that equals a programmable value.

- **Start bits:** in oversampled mode, a start bit that does not hold until mid-bit is discarded.
- **Framing errors:** after one, the search for a new start bit resumes half a bit later.
- **Line breaks:** a break is reported as two separate events, its start and its end. Only one null character is written for the whole break.
- **Full queue:** when the queue is full, the character is dropped and an overrun pulse is raised. The queue uses this pulse to mark its newest entry.

Top module: `brk_rx`

## Requirements
- R1: `char_len` code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. The first data bit received lands in `wr_char[0]`, and bits above the length read as zero.
- R2: `par_mode` 1 selects even parity and 2 selects odd parity, counted over the data bits plus the parity bit. A mismatch sets `wr_par_err`.
- R3: `par_mode` 0 means no parity bit is expected, and `wr_par_err` is 0. `par_mode` 3 expects a parity bit equal to `par_fix`, and flags a parity error otherwise.
- R4: In oversampled mode, a low level seen at an idle tick is re-checked half a bit later. If the line is then high, the receiver returns to idle and writes nothing.
- R5: A stop bit sampled low on a non-break character sets `wr_frm_err`. In oversampled mode the start-bit search resumes half a bit after that stop sample, so a start bit that begins right at the end of the bad stop bit is still received.
- R6: A character whose data bits are all zero, whose parity bit (if present) is zero, and whose stop bit is low is a break. It is written once as 0x00 with `wr_frm_err` set, `brk_start` pulses in the same cycle, and nothing more is written while the line stays low.
- R7: During a break, `brk_end` pulses once, one cycle after the first tick that samples a high line, and never together with `brk_start`.
- R8: `wr_cmp_match` is 1 when the zero-extended character equals `cmp_char`.
- R9: If `fifo_full` is high at the stop-bit sample, `wr_en` stays low and `ovr_pulse` pulses for one cycle instead.
- R10: With `mode_x1` high, each `samp_en` tick samples one bit: the start bit is taken at the first low tick, and the data bits follow on the next ticks.
- R11: After reset `wr_en`, `ovr_pulse`, `brk_start` and `brk_end` are low. All write-side outputs are registered and appear one cycle after the stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample tick enable (16 per bit, or 1 per bit in single-tick mode) |
| mode_x1 | input | 1 | 1 = one tick per bit, 0 = sixteen ticks per bit |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 fixed |
| par_fix | input | 1 | Expected parity level in fixed mode |
| cmp_char | input | 8 | Compare value |
| rxd | input | 1 | Serial line, idle high |
| fifo_full | input | 1 | Downstream queue is full |
| wr_en | output | 1 | One-cycle write of a received character |
| wr_char | output | 8 | Received character, zero-extended |
| wr_par_err | output | 1 | Parity error for this character |
| wr_frm_err | output | 1 | Stop bit was low |
| wr_cmp_match | output | 1 | Character equals the compare value |
| ovr_pulse | output | 1 | Character dropped because the queue was full |
| brk_start | output | 1 | Break detected |
| brk_end | output | 1 | Line returned high after a break |

## Verification
Some properties are checked on every cycle:
- a write and an overrun never coincide, and no write follows a cycle in which the queue was full;
- a break start always carries a null character with a framing error;
- a break end only follows a high sample;
- written characters never have bits set above the selected length;
- no parity error appears while parity is off.

The exact parity results, the false-start rejection, the half-bit resume after a framing error, single-tick sampling and compare matches depend on the shape of the serial waveform. Only the bench's scenarios can show those.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FIXED = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD,
    ST_BRK
  } rx_state_e;
endpackage

// File: rtl/rxa_phase.sv
module rxa_phase #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic x1,
  input  logic clr,
  output logic full_stb,
  output logic half_stb
);
  localparam int CW   = $clog2(OVS);
  localparam int LAST = OVS - 1;
  localparam int HALF = OVS / 2 - 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (samp_en) begin
      cnt_d = (cnt_q == CW'(LAST)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full_stb = samp_en && (x1 || (cnt_q == CW'(LAST)));
  assign half_stb = samp_en && (x1 || (cnt_q == CW'(HALF)));
endmodule

// File: rtl/rxa_check.sv
module rxa_check
  import rxa_pkg::*;
(
  input  logic [7:0] data,
  input  logic       pbit,
  input  logic [1:0] pmode,
  input  logic       pfix,
  input  logic [7:0] cmp,
  output logic       perr,
  output logic       match
);
  logic ones_odd;

  always_comb begin
    ones_odd = ^{data, pbit};
    case (par_mode_e'(pmode))
      PAR_EVEN:  perr = ones_odd;
      PAR_ODD:   perr = !ones_odd;
      PAR_FIXED: perr = (pbit != pfix);
      default:   perr = 1'b0;
    endcase
  end

  assign match = (data == cmp);
endmodule

// File: rtl/rxa_framer.sv
module rxa_framer
  import rxa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       x1,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic [1:0] pmode,
  input  logic       fifo_full,
  input  logic       full_stb,
  input  logic       half_stb,
  input  logic       perr_in,
  input  logic       match_in,
  output logic       clr,
  output logic [7:0] data_o,
  output logic       pbit_o,
  output logic       wr_en,
  output logic [7:0] wr_char,
  output logic       wr_par_err,
  output logic       wr_frm_err,
  output logic       wr_cmp_match,
  output logic       ovr_pulse,
  output logic       brk_start,
  output logic       brk_end
);
  rx_state_e  state_q, state_d;
  logic [2:0] bcnt_q;
  logic [7:0] data_q;
  logic       pbit_q;
  logic [2:0] last_idx;
  logic       has_par, is_brk, stop_stb;

  assign last_idx = {1'b0, char_len} + 3'd4;
  assign has_par  = (par_mode_e'(pmode) != PAR_NONE);
  assign is_brk   = (data_q == 8'h00) && (!has_par || !pbit_q);
  assign stop_stb = (state_q == ST_STOP) && full_stb;

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE: if (samp_en && !rxd) begin
        clr     = 1'b1;
        state_d = x1 ? ST_DATA : ST_START;
      end
      ST_START: if (half_stb) begin
        if (rxd) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_DATA;
          clr     = 1'b1;
        end
      end
      ST_DATA: if (full_stb && bcnt_q == last_idx) state_d = has_par ? ST_PAR : ST_STOP;
      ST_PAR:  if (full_stb) state_d = ST_STOP;
      ST_STOP: if (full_stb) begin
        if (rxd)         state_d = ST_IDLE;
        else if (is_brk) state_d = ST_BRK;
        else if (x1)     state_d = ST_IDLE;
        else begin
          state_d = ST_HOLD;
          clr     = 1'b1;
        end
      end
      ST_HOLD: if (half_stb) state_d = ST_IDLE;
      ST_BRK:  if (samp_en && rxd) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      bcnt_q       <= '0;
      data_q       <= '0;
      pbit_q       <= 1'b0;
      wr_en        <= 1'b0;
      wr_char      <= '0;
      wr_par_err   <= 1'b0;
      wr_frm_err   <= 1'b0;
      wr_cmp_match <= 1'b0;
      ovr_pulse    <= 1'b0;
      brk_start    <= 1'b0;
      brk_end      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_DATA) bcnt_q <= '0;
      else if (full_stb)      bcnt_q <= bcnt_q + 3'd1;
      if (state_q == ST_IDLE || state_q == ST_START) begin
        data_q <= '0;
        pbit_q <= 1'b0;
      end else begin
        if (state_q == ST_DATA && full_stb) data_q[bcnt_q] <= rxd;
        if (state_q == ST_PAR && full_stb)  pbit_q <= rxd;
      end
      wr_en     <= stop_stb && !fifo_full;
      ovr_pulse <= stop_stb && fifo_full;
      brk_start <= stop_stb && !rxd && is_brk;
      brk_end   <= (state_q == ST_BRK) && samp_en && rxd;
      if (stop_stb) begin
        wr_char      <= data_q;
        wr_par_err   <= perr_in;
        wr_frm_err   <= !rxd;
        wr_cmp_match <= match_in;
      end
    end
  end

  assign data_o = data_q;
  assign pbit_o = pbit_q;
endmodule

// File: rtl/brk_rx.sv
module brk_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       mode_x1,
  input  logic [1:0] char_len,
  input  logic [1:0] par_mode,
  input  logic       par_fix,
  input  logic [7:0] cmp_char,
  input  logic       rxd,
  input  logic       fifo_full,
  output logic       wr_en,
  output logic [7:0] wr_char,
  output logic       wr_par_err,
  output logic       wr_frm_err,
  output logic       wr_cmp_match,
  output logic       ovr_pulse,
  output logic       brk_start,
  output logic       brk_end
);
  logic       clr, full_stb, half_stb, perr, match, pbit;
  logic [7:0] data;

  rxa_phase #(.OVS(OVS)) u_phase (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .x1(mode_x1), .clr(clr),
    .full_stb(full_stb), .half_stb(half_stb)
  );

  rxa_check u_check (
    .data(data), .pbit(pbit), .pmode(par_mode), .pfix(par_fix), .cmp(cmp_char),
    .perr(perr), .match(match)
  );

  rxa_framer u_framer (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .x1(mode_x1), .rxd(rxd),
    .char_len(char_len), .pmode(par_mode), .fifo_full(fifo_full),
    .full_stb(full_stb), .half_stb(half_stb), .perr_in(perr), .match_in(match),
    .clr(clr), .data_o(data), .pbit_o(pbit),
    .wr_en(wr_en), .wr_char(wr_char), .wr_par_err(wr_par_err),
    .wr_frm_err(wr_frm_err), .wr_cmp_match(wr_cmp_match),
    .ovr_pulse(ovr_pulse), .brk_start(brk_start), .brk_end(brk_end)
  );
endmodule

// File: rtl/brk_rx_sva.sv
module brk_rx_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_full,
  input logic       rxd,
  input logic [1:0] char_len,
  input logic [1:0] par_mode,
  input logic       wr_en,
  input logic [7:0] wr_char,
  input logic       wr_par_err,
  input logic       wr_frm_err,
  input logic       ovr_pulse,
  input logic       brk_start,
  input logic       brk_end
);
  AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(fifo_full)); // R9
  AST_OVR_NOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |-> !wr_en); // R9
  AST_BRK_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> (wr_char == 8'h00 && wr_frm_err)); // R6
  AST_BRK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_start && brk_end)); // R7
  AST_BRK_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> $past(rxd)); // R7
  AST_SHORT_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $stable(char_len)) |-> ((wr_char >> (4'd5 + {2'b00, char_len})) == 8'h00)); // R1
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R11
  AST_PERR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && par_mode == 2'd0 && $stable(par_mode)) |-> !wr_par_err); // R3
endmodule

bind brk_rx brk_rx_sva u_sva (
  .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .rxd(rxd),
  .char_len(char_len), .par_mode(par_mode), .wr_en(wr_en), .wr_char(wr_char),
  .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .ovr_pulse(ovr_pulse),
  .brk_start(brk_start), .brk_end(brk_end)
);

// File: tb/brk_rx_tb_top.sv
module brk_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 12;
  // {len[17:16], pmode[15:14], fix[13], data[12:5], pbit[4], stop[3], eperr[2], eferr[1], ecmp[0]}
  localparam logic [17:0] VECS [NV] = '{
    {2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd3, 2'd1, 1'b0, 8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd1, 1'b0, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd2, 1'b0, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'd2, 1'b0, 8'h55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 1'b0, 8'h1F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd3, 1'b1, 8'h2A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd3, 1'b1, 8'h2A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd0, 2'd1, 1'b0, 8'h1A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'd0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, samp_en = 1'b1, mode_x1 = 1'b0;
  logic [1:0] char_len = 2'd3, par_mode = 2'd0;
  logic par_fix = 1'b0, rxd = 1'b1, fifo_full = 1'b0;
  logic [7:0] cmp_char = 8'h5A;
  logic wr_en, wr_par_err, wr_frm_err, wr_cmp_match, ovr_pulse, brk_start, brk_end;
  logic [7:0] wr_char;

  int nchk = 0, nfail = 0, wcnt = 0, ocnt = 0, bscnt = 0, becnt = 0;
  logic [7:0] l_char = '0;
  logic l_perr = 1'b0, l_ferr = 1'b0, l_cmp = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  brk_rx dut_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .mode_x1(mode_x1),
    .char_len(char_len), .par_mode(par_mode), .par_fix(par_fix),
    .cmp_char(cmp_char), .rxd(rxd), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_char(wr_char), .wr_par_err(wr_par_err),
    .wr_frm_err(wr_frm_err), .wr_cmp_match(wr_cmp_match),
    .ovr_pulse(ovr_pulse), .brk_start(brk_start), .brk_end(brk_end)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      wcnt++;
      l_char = wr_char; l_perr = wr_par_err; l_ferr = wr_frm_err; l_cmp = wr_cmp_match;
    end
    if (ovr_pulse) ocnt++;
    if (brk_start) bscnt++;
    if (brk_end)   becnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit16(input logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send16(input logic [1:0] len, input logic [1:0] pm, input logic [7:0] d,
                        input logic pb, input logic stp, input int gap);
    bit16(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) bit16(d[i]);
    if (pm != 2'd0) bit16(pb);
    bit16(stp);
    rxd = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic tick1(input logic b);
    rxd = b;
    @(negedge clk); samp_en = 1'b1;
    @(negedge clk); samp_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!wr_en && !ovr_pulse && !brk_start && !brk_end, "R11 outputs low in reset",
        {wr_en, ovr_pulse, brk_start, brk_end}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(wcnt == 0 && ocnt == 0, "R11 idle after reset", wcnt, 0);

    // Table: R1 lengths, R2 even/odd, R3 none/fixed, R5 framing, R8 compare
    for (int i = 0; i < NV; i++) begin
      char_len = VECS[i][17:16];
      par_mode = VECS[i][15:14];
      par_fix  = VECS[i][13];
      w0 = wcnt;
      send16(VECS[i][17:16], VECS[i][15:14], VECS[i][12:5], VECS[i][4], VECS[i][3], 24);
      chk(wcnt == w0 + 1, "R1 one write per character", wcnt - w0, 1);
      chk(l_char == VECS[i][12:5], "R1 character value", l_char, VECS[i][12:5]);
      chk(l_perr == VECS[i][2], "R2 R3 parity flag", l_perr, VECS[i][2]);
      chk(l_ferr == VECS[i][1], "R5 framing flag", l_ferr, VECS[i][1]);
      chk(l_cmp == VECS[i][0], "R8 compare flag", l_cmp, VECS[i][0]);
    end

    char_len = 2'd3; par_mode = 2'd0;
    // R4 false start: short low pulse
    w0 = wcnt;
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    chk(wcnt == w0, "R4 false start ignored", wcnt - w0, 0);
    send16(2'd3, 2'd0, 8'h96, 1'b0, 1'b1, 24);
    chk(wcnt == w0 + 1 && l_char == 8'h96, "R4 receive after false start", l_char, 8'h96);

    // R5 resume half a bit after framing error: next start abuts the bad stop bit
    w0 = wcnt;
    send16(2'd3, 2'd0, 8'h81, 1'b0, 1'b0, 0);
    send16(2'd3, 2'd0, 8'h3C, 1'b0, 1'b1, 24);
    chk(wcnt == w0 + 2, "R5 both characters written", wcnt - w0, 2);
    chk(l_char == 8'h3C && !l_ferr, "R5 character after framing error", l_char, 8'h3C);

    // R6 / R7 break
    w0 = wcnt;
    bit16(1'b0);
    for (int i = 0; i < 8; i++) bit16(1'b0);
    bit16(1'b0);
    repeat (60) @(negedge clk);
    chk(wcnt == w0 + 1, "R6 single null write", wcnt - w0, 1);
    chk(l_char == 8'h00 && l_ferr, "R6 null with framing error", {l_char, l_ferr}, 1);
    chk(bscnt == 1, "R6 break start pulse", bscnt, 1);
    chk(becnt == 0, "R7 no end while low", becnt, 0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk(becnt == 1, "R7 break end pulse", becnt, 1);
    chk(wcnt == w0 + 1, "R6 no extra write at end", wcnt - w0, 1);
    repeat (20) @(negedge clk);

    // R9 overrun
    w0 = wcnt;
    fifo_full = 1'b1;
    send16(2'd3, 2'd0, 8'h11, 1'b0, 1'b1, 24);
    chk(wcnt == w0, "R9 dropped when full", wcnt - w0, 0);
    chk(ocnt == 1, "R9 overrun pulse", ocnt, 1);
    fifo_full = 1'b0;

    // R10 single-tick mode
    mode_x1 = 1'b1; samp_en = 1'b0;
    repeat (4) @(negedge clk);
    w0 = wcnt;
    tick1(1'b0);
    for (int i = 0; i < 8; i++) tick1(i[0] ? 1'b1 : (i == 6 || i == 7 ? 1'b1 : 1'b0));
    tick1(1'b1);
    tick1(1'b1); tick1(1'b1);
    // data bits 0..7 = 0,1,0,1,0,1,1,1 -> 0xEA
    chk(wcnt == w0 + 1, "R10 one write", wcnt - w0, 1);
    chk(l_char == 8'hEA && !l_ferr, "R10 character", l_char, 8'hEA);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule